// File: doc/BRIEF.md
# Programmable Galois-Field CRC and Random Generator

This block is a 32-bit Galois-field shift engine that serves two purposes from one state register. In checksum mode it folds incoming bytes or words into a cyclic redundancy value under a polynomial that software may load at any time. In generator mode the same register runs as a linear feedback shift register and emits pseudo-random data. Entropy mixing can be added from a single external noise bit. When the generator is off, that noise bit can also be passed straight to the output so the noise source can be characterized.

The engine works internally in least-significant-bit-first form. A bit-order control selects most-significant-bit-first processing. In that mode, input data bits are consumed from the top bit down, and the polynomial and state registers read and write bit-reversed. A conventional forward polynomial can therefore be written directly.

Input data arrives on a valid/ready stream. `in_ready` is high exactly while checksum mode is active, and a beat transfers on a clock edge where `in_valid` and `in_ready` are both high. Random data leaves on a valid/ready stream. Holding `rnd_ready` low freezes both the generator state and the offered value. The offered value is taken on an edge where `rnd_valid` and `rnd_ready` are both high.

Top module: `gf32_engine`

## Requirements
- R1: After reset, the polynomial reads 0xEDB88320 and the state reads 0xFFFFFFFF, both in least-first view. All modes are off, so `in_ready` and `rnd_valid` are low.
- R2: In checksum mode with least-first order, each accepted byte (`in_word`=0, data in `in_data[7:0]`) advances the state by 8 reflected steps in one clock. A step is: feedback = state bit 0 XOR data bit; state = (state >> 1) XOR (feedback ? polynomial : 0). Data bit 0 is used first. The ASCII string "123456789" from the reset state leaves 0x340BC6D9.
- R3: A word beat (`in_word`=1) advances the state by 32 steps in one clock, using all 32 data bits. In least-first order it matches four byte beats of its bytes taken low byte first.
- R4: With `msb_first`=1, polynomial and state writes and reads are bit-reversed relative to the internal form. The reset polynomial then reads 0x04C11DB7. Each data byte or word is consumed from its top bit down. "123456789" from state 0xFFFFFFFF leaves the state reading 0x0376E6E7.
- R5: A control write that asks for both checksum and generator mode leaves checksum mode off. `in_ready` stays low.
- R6: When checksum mode is off, `in_ready` is low and input beats leave the state unchanged.
- R7: With the generator on and entropy off, each handshake advances the state by 8 steps with zero data. `rnd_wide`=1, and `rnd_data[i]` is the feedback bit of step i.
- R8: With the generator and entropy both on, each handshake advances the state by one step whose feedback also XORs `ent_bit`. `rnd_wide`=0, `rnd_data[0]` is that feedback bit, and `rnd_data[7:1]`=0.
- R9: With the generator off and entropy on, `rnd_valid`=1 and `rnd_wide`=0. `rnd_data[0]` is `ent_bit`, `rnd_data[7:1]`=0, and the state never changes.
- R10: While `rnd_ready` is low, the state and `rnd_data` hold their values. This applies when `ent_bit` is steady and there are no writes.
- R11: A state write takes priority over an engine update in the same cycle. The written value is read back next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the four mode bits below |
| cfg_crc_en | input | 1 | Checksum mode request |
| cfg_msb_first | input | 1 | 1 = most-significant-bit-first order |
| cfg_prng_en | input | 1 | Generator mode |
| cfg_ent_en | input | 1 | Entropy mixing / raw entropy output |
| poly_we | input | 1 | Polynomial write strobe |
| poly_wdata | input | 32 | Polynomial write value (order view) |
| poly_rdata | output | 32 | Polynomial read value (order view) |
| state_we | input | 1 | State write strobe |
| state_wdata | input | 32 | State write value (order view) |
| state_rdata | output | 32 | State read value (order view) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high |
| in_data | input | 32 | Input data |
| in_word | input | 1 | 1 = 32-bit beat, 0 = byte in bits 7:0 |
| ent_bit | input | 1 | External noise bit |
| rnd_valid | output | 1 | Random output offered |
| rnd_ready | input | 1 | Consumer takes random output |
| rnd_data | output | 8 | Random byte or bit (bit 0) |
| rnd_wide | output | 1 | 1 = eight valid bits, 0 = one valid bit |

## Verification
The assertions assume that the mode bits change only through `cfg_we`, and they exclude any cycle carrying a control write. A write that flips the bit order changes the view of both registers without touching their contents. The hold check also assumes there is no input handshake, so it covers only cycles with checksum mode off. The stimulus drives every input one nanosecond after the rising edge and keeps control writes in cycles of their own. In every back-pressure window it holds `ent_bit` steady and issues no writes.

// File: rtl/gf32_pkg.sv
package gf32_pkg;
  typedef struct packed {
    logic crc_en;
    logic msb_first;
    logic prng_en;
    logic ent_en;
  } gf_ctl_t;
endpackage

// File: rtl/gf32_ctrl.sv
module gf32_ctrl
  import gf32_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we,
  input  logic    crc_req,
  input  logic    msb_req,
  input  logic    prng_req,
  input  logic    ent_req,
  output gf_ctl_t ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (we) begin
      ctl.crc_en    <= crc_req & ~prng_req;
      ctl.msb_first <= msb_req;
      ctl.prng_en   <= prng_req;
      ctl.ent_en    <= ent_req;
    end
  end
endmodule

// File: rtl/gf32_bitrev.sv
module gf32_bitrev #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign y[i] = a[W-1-i];
  end
endmodule

// File: rtl/gf32_step_chain.sv
module gf32_step_chain #(
  parameter int W      = 32,
  parameter int STEPS  = 32,
  parameter int BYTE_W = 8
) (
  input  logic [W-1:0]     s_in,
  input  logic [W-1:0]     poly,
  input  logic [STEPS-1:0] d,
  input  logic             e0,
  output logic [W-1:0]     s_one,
  output logic [W-1:0]     s_byte,
  output logic [W-1:0]     s_all,
  output logic [STEPS-1:0] fb
);
  logic [W-1:0] st [STEPS+1];

  assign st[0] = s_in;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    logic mix;
    if (i == 0) begin : g_first
      assign mix = e0;
    end else begin : g_rest
      assign mix = 1'b0;
    end
    assign fb[i]   = st[i][0] ^ d[i] ^ mix;
    assign st[i+1] = {1'b0, st[i][W-1:1]} ^ (fb[i] ? poly : '0);
  end

  assign s_one  = st[1];
  assign s_byte = st[BYTE_W];
  assign s_all  = st[STEPS];
endmodule

// File: rtl/gf32_engine.sv
module gf32_engine
  import gf32_pkg::*;
#(
  parameter int             W          = 32,
  parameter int             BYTE_W     = 8,
  parameter logic [W-1:0]   POLY_INIT  = 32'hEDB88320,
  parameter logic [W-1:0]   STATE_INIT = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_crc_en,
  input  logic              cfg_msb_first,
  input  logic              cfg_prng_en,
  input  logic              cfg_ent_en,
  input  logic              poly_we,
  input  logic [W-1:0]      poly_wdata,
  output logic [W-1:0]      poly_rdata,
  input  logic              state_we,
  input  logic [W-1:0]      state_wdata,
  output logic [W-1:0]      state_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_data,
  input  logic              in_word,
  input  logic              ent_bit,
  output logic              rnd_valid,
  input  logic              rnd_ready,
  output logic [BYTE_W-1:0] rnd_data,
  output logic              rnd_wide
);
  localparam int FILL = W - BYTE_W;

  gf_ctl_t      ctl;
  logic [W-1:0] poly_q, st_q;
  logic [W-1:0] poly_w_rev, st_w_rev, poly_q_rev, st_q_rev;
  logic [W-1:0] word_rev, byte_rev;
  logic [W-1:0] chain_d;
  logic [W-1:0] s_one, s_byte, s_all;
  logic [W-1:0] fb;
  logic         e0, crc_take, rnd_take;

  gf32_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .crc_req(cfg_crc_en), .msb_req(cfg_msb_first),
    .prng_req(cfg_prng_en), .ent_req(cfg_ent_en), .ctl(ctl)
  );

  gf32_bitrev #(.W(W)) u_rev_pw (.a(poly_wdata),  .y(poly_w_rev));
  gf32_bitrev #(.W(W)) u_rev_sw (.a(state_wdata), .y(st_w_rev));
  gf32_bitrev #(.W(W)) u_rev_pq (.a(poly_q),      .y(poly_q_rev));
  gf32_bitrev #(.W(W)) u_rev_sq (.a(st_q),        .y(st_q_rev));
  gf32_bitrev #(.W(W)) u_rev_dw (.a(in_data),     .y(word_rev));
  gf32_bitrev #(.W(W)) u_rev_db (.a({in_data[BYTE_W-1:0], {FILL{1'b0}}}), .y(byte_rev));

  assign poly_rdata  = ctl.msb_first ? poly_q_rev : poly_q;
  assign state_rdata = ctl.msb_first ? st_q_rev   : st_q;

  // data bits in consumption order, step 0 first; zero outside checksum mode
  always_comb begin
    chain_d = '0;
    if (ctl.crc_en) begin
      if (in_word)
        chain_d = ctl.msb_first ? word_rev : in_data;
      else
        chain_d = {{FILL{1'b0}},
                   ctl.msb_first ? byte_rev[BYTE_W-1:0] : in_data[BYTE_W-1:0]};
    end
  end

  assign e0 = ctl.prng_en & ctl.ent_en & ent_bit;

  gf32_step_chain #(.W(W), .STEPS(W), .BYTE_W(BYTE_W)) u_chain (
    .s_in(st_q), .poly(poly_q), .d(chain_d), .e0(e0),
    .s_one(s_one), .s_byte(s_byte), .s_all(s_all), .fb(fb)
  );

  assign in_ready  = ctl.crc_en;
  assign rnd_valid = ctl.prng_en | ctl.ent_en;
  assign rnd_wide  = ctl.prng_en & ~ctl.ent_en;
  assign crc_take  = in_valid & in_ready;
  assign rnd_take  = rnd_valid & rnd_ready & ctl.prng_en;

  always_comb begin
    rnd_data = '0;
    if (ctl.prng_en && !ctl.ent_en)
      rnd_data = fb[BYTE_W-1:0];
    else if (ctl.prng_en)
      rnd_data[0] = fb[0];
    else if (ctl.ent_en)
      rnd_data[0] = ent_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= POLY_INIT;
      st_q   <= STATE_INIT;
    end else begin
      if (poly_we)
        poly_q <= ctl.msb_first ? poly_w_rev : poly_wdata;
      if (state_we)
        st_q <= ctl.msb_first ? st_w_rev : state_wdata;
      else if (crc_take)
        st_q <= in_word ? s_all : s_byte;
      else if (rnd_take)
        st_q <= ctl.ent_en ? s_one : s_byte;
    end
  end
endmodule

// File: rtl/gf32_engine_chk.sv
module gf32_engine_chk #(
  parameter int W      = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_crc_en,
  input logic              cfg_prng_en,
  input logic              poly_we,
  input logic [W-1:0]      poly_wdata,
  input logic [W-1:0]      poly_rdata,
  input logic              state_we,
  input logic [W-1:0]      state_wdata,
  input logic [W-1:0]      state_rdata,
  input logic              in_ready,
  input logic              rnd_valid,
  input logic              rnd_ready,
  input logic [BYTE_W-1:0] rnd_data,
  input logic              rnd_wide
);
  p_refuse_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_crc_en && cfg_prng_en) |=> !in_ready);

  p_gen_excludes_crc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid && rnd_wide) |-> !in_ready);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !rnd_valid && !state_we && !cfg_we) |=> $stable(state_rdata));

  p_narrow_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid && !rnd_wide) |-> (rnd_data[BYTE_W-1:1] == '0));

  p_wide_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_wide |-> rnd_valid);

  p_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_valid && !rnd_ready && !in_ready && !state_we && !cfg_we)
      |=> $stable(state_rdata));

  p_state_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_we && !cfg_we) |=> (state_rdata == $past(state_wdata)));

  p_poly_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (poly_we && !cfg_we) |=> (poly_rdata == $past(poly_wdata)));
endmodule

bind gf32_engine gf32_engine_chk #(.W(W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_crc_en(cfg_crc_en),
  .cfg_prng_en(cfg_prng_en), .poly_we(poly_we), .poly_wdata(poly_wdata),
  .poly_rdata(poly_rdata), .state_we(state_we), .state_wdata(state_wdata),
  .state_rdata(state_rdata), .in_ready(in_ready), .rnd_valid(rnd_valid),
  .rnd_ready(rnd_ready), .rnd_data(rnd_data), .rnd_wide(rnd_wide)
);

// File: tb/gf32_engine_bench.sv
`timescale 1ns/1ps
module gf32_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cfg_crc_en = 0, cfg_msb_first = 0, cfg_prng_en = 0, cfg_ent_en = 0;
  logic        poly_we = 0, state_we = 0;
  logic [31:0] poly_wdata = '0, state_wdata = '0;
  logic [31:0] poly_rdata, state_rdata;
  logic        in_valid = 0, in_word = 0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        ent_bit = 0;
  logic        rnd_valid, rnd_ready = 0, rnd_wide;
  logic [7:0]  rnd_data;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  bit mon_en = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [31:0] m_s;
  localparam logic [31:0] P_REF = 32'hEDB88320;
  logic [15:0] nz = 16'hACE1;

  always #2.5 clk = ~clk;

  gf32_engine u_gf32_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_crc_en(cfg_crc_en),
    .cfg_msb_first(cfg_msb_first), .cfg_prng_en(cfg_prng_en), .cfg_ent_en(cfg_ent_en),
    .poly_we(poly_we), .poly_wdata(poly_wdata), .poly_rdata(poly_rdata),
    .state_we(state_we), .state_wdata(state_wdata), .state_rdata(state_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_word(in_word),
    .ent_bit(ent_bit), .rnd_valid(rnd_valid), .rnd_ready(rnd_ready),
    .rnd_data(rnd_data), .rnd_wide(rnd_wide)
  );

  function automatic logic [31:0] rev32(input logic [31:0] a);
    for (int i = 0; i < 32; i++) rev32[i] = a[31-i];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr_cfg(input logic c, input logic m, input logic p, input logic e);
    @(posedge clk); #1;
    cfg_we = 1; cfg_crc_en = c; cfg_msb_first = m; cfg_prng_en = p; cfg_ent_en = e;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic wr_state(input logic [31:0] v);
    @(posedge clk); #1; state_we = 1; state_wdata = v;
    @(posedge clk); #1; state_we = 0;
  endtask

  task automatic wr_poly(input logic [31:0] v);
    @(posedge clk); #1; poly_we = 1; poly_wdata = v;
    @(posedge clk); #1; poly_we = 0;
  endtask

  task automatic send(input logic [31:0] d, input logic w);
    @(posedge clk); #1; in_valid = 1; in_data = d; in_word = w;
    @(posedge clk); #1; in_valid = 0;
  endtask

  task automatic send_str(input string s, input int from);
    for (int i = from; i < s.len(); i++) send({24'h0, s[i]}, 1'b0);
  endtask

  // monitor: compares each taken random item with the scoreboard head
  always @(negedge clk) begin
    if (mon_en && rnd_valid && rnd_ready) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 unexpected output actual=%h expected=none", {rnd_wide, rnd_data});
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {23'h0, rnd_wide, rnd_data}, {23'h0, e});
      end
    end
  end

  // driver: one cycle of the random stream; mode 0 byte gen, 1 mixed gen, 2 raw noise
  task automatic drive_rnd(input int mode, input logic rdy);
    logic [7:0] ob;
    logic fbv;
    @(posedge clk); #1;
    nz = {nz[14:0], nz[15] ^ nz[13] ^ nz[12] ^ nz[10]};
    ent_bit = nz[0];
    rnd_ready = rdy;
    if (rdy) begin
      ob = '0;
      if (mode == 0) begin
        for (int i = 0; i < 8; i++) begin
          fbv = m_s[0];
          ob[i] = fbv;
          m_s = (m_s >> 1) ^ (fbv ? P_REF : 32'h0);
        end
        exp_q.push_back({1'b1, ob}); tag_q.push_back("R7");
      end else if (mode == 1) begin
        fbv = m_s[0] ^ ent_bit;
        m_s = (m_s >> 1) ^ (fbv ? P_REF : 32'h0);
        exp_q.push_back({1'b0, 7'h0, fbv}); tag_q.push_back("R8");
      end else begin
        exp_q.push_back({1'b0, 7'h0, ent_bit}); tag_q.push_back("R9");
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] hold_s;
    logic [7:0]  hold_d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 poly", poly_rdata, 32'hEDB88320);
    chk("R1 state", state_rdata, 32'hFFFFFFFF);
    chk("R1 ready", {31'h0, in_ready}, 32'h0);
    chk("R1 rvalid", {31'h0, rnd_valid}, 32'h0);

    // R6: checksum off, beats ignored
    send(32'h0000_00A5, 1'b0);
    @(negedge clk);
    chk("R6 ready", {31'h0, in_ready}, 32'h0);
    chk("R6 state", state_rdata, 32'hFFFFFFFF);

    // R2: byte stream, least-first
    wr_cfg(1, 0, 0, 0);
    send_str("123456789", 0);
    @(negedge clk);
    chk("R2 crc", state_rdata, 32'h340BC6D9);

    // R3: word then bytes
    wr_state(32'hFFFFFFFF);
    send(32'h34333231, 1'b1);
    @(negedge clk);
    chk("R3 partial", state_rdata, 32'h9BE3E0A3 ^ 32'hFFFFFFFF);
    send_str("123456789", 4);
    @(negedge clk);
    chk("R3 crc", state_rdata, 32'h340BC6D9);

    // R4: msb-first view and processing
    wr_cfg(1, 1, 0, 0);
    @(negedge clk);
    chk("R4 poly view", poly_rdata, 32'h04C11DB7);
    wr_state(32'hFFFFFFFF);
    send_str("123456789", 0);
    @(negedge clk);
    chk("R4 crc", state_rdata, 32'h0376E6E7);
    wr_state(32'hFFFFFFFF);
    send(32'h31323334, 1'b1);
    send_str("123456789", 4);
    @(negedge clk);
    chk("R4 word crc", state_rdata, 32'h0376E6E7);
    wr_state(32'h12345678);
    wr_cfg(1, 0, 0, 0);
    @(negedge clk);
    chk("R4 state view", state_rdata, rev32(32'h12345678));

    // R11: state write beats a byte in the same cycle
    @(posedge clk); #1;
    in_valid = 1; in_data = 32'h55; in_word = 0; state_we = 1; state_wdata = 32'hCAFEF00D;
    @(posedge clk); #1; in_valid = 0; state_we = 0;
    @(negedge clk);
    chk("R11 state", state_rdata, 32'hCAFEF00D);

    // R5: both requested, checksum refused
    wr_cfg(1, 0, 1, 0);
    @(negedge clk);
    chk("R5 ready", {31'h0, in_ready}, 32'h0);
    chk("R5 wide", {30'h0, rnd_valid, rnd_wide}, 32'h3);

    // R7: byte generator with back-pressure pattern
    m_s = 32'hCAFEF00D;
    mon_en = 1;
    for (int i = 0; i < 40; i++) drive_rnd(0, (i % 3) != 2);
    @(posedge clk); #1; rnd_ready = 0;
    @(negedge clk);
    chk("R7 state", state_rdata, m_s);

    // R10: hold while not ready
    hold_s = state_rdata; hold_d = rnd_data;
    repeat (4) @(negedge clk);
    chk("R10 state", state_rdata, hold_s);
    chk("R10 data", {24'h0, rnd_data}, {24'h0, hold_d});

    // R8: mixed generator, one bit per take
    wr_cfg(0, 0, 1, 1);
    for (int i = 0; i < 40; i++) drive_rnd(1, (i % 4) != 3);
    @(posedge clk); #1; rnd_ready = 0;
    @(negedge clk);
    chk("R8 state", state_rdata, m_s);

    // R9: raw noise, state frozen
    wr_cfg(0, 0, 0, 1);
    for (int i = 0; i < 30; i++) drive_rnd(2, 1'b1);
    @(posedge clk); #1; rnd_ready = 0;
    @(negedge clk);
    chk("R9 state", state_rdata, m_s);
    mon_en = 0;
    chk("R7 queue drained", exp_q.size(), 0);

    // R4: polynomial written in msb view, read in both views
    wr_cfg(0, 1, 0, 0);
    wr_poly(32'h1EDC6F41);
    @(negedge clk);
    chk("R4 poly msb", poly_rdata, 32'h1EDC6F41);
    wr_cfg(0, 0, 0, 0);
    @(negedge clk);
    chk("R4 poly lsb", poly_rdata, rev32(32'h1EDC6F41));

    summary();
  end
endmodule